// File: doc/BRIEF.md
# FIFO Transfer-Ready Status Generator

This block holds one serial channel's transmit and receive byte queues, each with a fill-level count, and turns their levels into two active-low readiness strobes that a host or a block-move engine watches to know when to write or read data. The queues are filled and drained through simple push/pop ports; the serial shifter that would sit on the far side is not part of it.

What the readiness strobes mean depends on the configuration. With the queues disabled, each side behaves as a single holding register. With the queues enabled in per-character operation, the strobes follow empty/non-empty. In block-transfer operation, transmit-ready reports "room left" and receive-ready becomes hysteretic: it turns on when the receive level reaches a programmed threshold or a timeout is signalled, and it stays on until the receive queue has been fully drained. A spare multi-function output can be set to mirror receive-ready.

Top module: `xfer_ready_unit`

## Requirements
- R1: Each queue holds up to DEPTH (128) bytes when the queues are enabled; `tx_level`/`rx_level` give the number of stored bytes.
- R2: With `cfg_fifo_en`=0 each queue holds at most one byte (a push to a queue holding one byte is refused).
- R3: A push to a full queue is dropped, leaves level and contents unchanged, and raises that side's overflow flag for exactly the following cycle.
- R4: A pop from an empty queue is ignored and raises that side's underflow flag for exactly the following cycle.
- R5: Outside block mode (`cfg_fifo_en`=0, or `cfg_block_mode`=0), `rx_rdy_n` is 0 exactly when `rx_level` is non-zero.
- R6: Outside block mode, `tx_rdy_n` is 0 exactly when `tx_level` is zero.
- R7: In block mode (`cfg_fifo_en`=1 and `cfg_block_mode`=1), `rx_rdy_n` falls to 0 one cycle after `rx_level` is at or above the trigger, and once low stays low until one cycle after `rx_level` is seen at 0.
- R8: In block mode, `rx_timeout`=1 with a non-empty receive queue drives `rx_rdy_n` low on the next cycle even below the trigger.
- R9: A trigger value `cfg_rx_trig` of 0 acts as a trigger of 1.
- R10: In block mode, `tx_rdy_n` is 1 exactly when `tx_level` equals DEPTH.
- R11: `mf_n` equals `rx_rdy_n` when `cfg_mf_sel` is binary 10, and is 1 for every other value.
- R12: A 1-to-0 change of `cfg_fifo_en` empties both queues and clears the block-mode receive latch at the next clock edge; pushes and pops in that cycle are discarded without flags.
- R13: Bytes leave each queue in the order they entered; the read-data port shows the oldest stored byte while the queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | Queue enable |
| cfg_block_mode | input | 1 | Block-transfer mode select |
| cfg_rx_trig | input | 8 | Receive trigger level (0 treated as 1) |
| cfg_mf_sel | input | 2 | Multi-function output select (10 = receive-ready) |
| rx_timeout | input | 1 | Receive timeout event |
| tx_push | input | 1 | Write one byte into the transmit queue |
| tx_wdata | input | 8 | Transmit write data |
| tx_pop | input | 1 | Remove the oldest transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Write one byte into the receive queue |
| rx_wdata | input | 8 | Receive write data |
| rx_pop | input | 1 | Remove the oldest receive byte |
| rx_rdata | output | 8 | Oldest receive byte |
| tx_level | output | 8 | Transmit queue fill level |
| rx_level | output | 8 | Receive queue fill level |
| tx_ovf | output | 1 | Transmit push refused (one cycle) |
| tx_unf | output | 1 | Transmit pop on empty (one cycle) |
| rx_ovf | output | 1 | Receive push refused (one cycle) |
| rx_unf | output | 1 | Receive pop on empty (one cycle) |
| tx_rdy_n | output | 1 | Active-low transmit-ready |
| rx_rdy_n | output | 1 | Active-low receive-ready |
| mf_n | output | 1 | Multi-function output |

## Verification
On every cycle the assertions hold the level bounds in each mode, the overflow and underflow flag causes, the empty/non-empty meaning of the strobes outside block mode, the full-only meaning of transmit-ready in block mode, the rule that block-mode receive-ready only releases after an empty level, the multi-function gating and the flush on disable. What the bench's scenarios alone can show is data ordering, the exact cycle at which the hysteretic latch sets from the trigger, from the timeout or from a zero trigger, and the interplay of mode changes with traffic, all checked against a queue-based reference model compared on every clock.

// File: rtl/xfer_ready_pkg.sv
package xfer_ready_pkg;

    localparam int TRIG_W = 8;
    localparam logic [1:0] MF_SEL_RXRDY = 2'b10;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_CHAR  = 2'd1,
        MODE_BLOCK = 2'd2
    } rdy_mode_e;

    typedef struct packed {
        logic              fifo_en;
        logic              block_mode;
        logic [TRIG_W-1:0] rx_trig;
        logic [1:0]        mf_sel;
    } rdy_cfg_t;

    typedef struct packed {
        logic push_ok;
        logic pop_ok;
        logic ovf;
        logic unf;
    } fifo_op_t;

    function automatic rdy_mode_e decode_mode(logic en, logic blk);
        if (!en)
            return MODE_HOLD;
        else if (blk)
            return MODE_BLOCK;
        else
            return MODE_CHAR;
    endfunction

    function automatic logic [TRIG_W-1:0] eff_trig(logic [TRIG_W-1:0] t);
        return (t == '0) ? TRIG_W'(1) : t;
    endfunction

endpackage

// File: rtl/xfer_byte_queue.sv
module xfer_byte_queue
    import xfer_ready_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              single,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  level,
    output logic              ovf,
    output logic              unf
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  cap;
    fifo_op_t          op;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        cap        = single ? LVL_W'(1) : LVL_W'(DEPTH);
        op.pop_ok  = pop && (level != '0) && !flush;
        op.unf     = pop && (level == '0) && !flush;
        op.push_ok = push && (level < cap) && !flush;
        op.ovf     = push && (level >= cap) && !flush;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            ovf <= op.ovf;
            unf <= op.unf;
            if (op.push_ok) wr_ptr <= bump(wr_ptr);
            if (op.pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({op.push_ok, op.pop_ok})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (op.push_ok) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];

endmodule

// File: rtl/xfer_ready_logic.sv
module xfer_ready_logic
    import xfer_ready_pkg::*;
#(
    parameter int DEPTH  = 128,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  rdy_cfg_t         cfg,
    input  logic             rx_timeout,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    output logic             tx_rdy_n,
    output logic             rx_rdy_n,
    output logic             mf_n
);

    rdy_mode_e mode;
    logic      blk_latch;
    logic      rx_hit;

    always_comb begin
        mode   = decode_mode(cfg.fifo_en, cfg.block_mode);
        rx_hit = (int'(rx_level) >= int'(eff_trig(cfg.rx_trig))) || rx_timeout;
    end

    always_ff @(posedge clk) begin
        if (rst || mode != MODE_BLOCK || rx_level == '0)
            blk_latch <= 1'b0;
        else if (rx_hit)
            blk_latch <= 1'b1;
    end

    always_comb begin
        unique case (mode)
            MODE_BLOCK: begin
                tx_rdy_n = (tx_level == LVL_W'(DEPTH));
                rx_rdy_n = !blk_latch;
            end
            default: begin
                tx_rdy_n = (tx_level != '0);
                rx_rdy_n = (rx_level == '0);
            end
        endcase
        mf_n = (cfg.mf_sel == MF_SEL_RXRDY) ? rx_rdy_n : 1'b1;
    end

endmodule

// File: rtl/xfer_ready_unit.sv
module xfer_ready_unit
    import xfer_ready_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_fifo_en,
    input  logic              cfg_block_mode,
    input  logic [TRIG_W-1:0] cfg_rx_trig,
    input  logic [1:0]        cfg_mf_sel,
    input  logic              rx_timeout,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [LVL_W-1:0]  tx_level,
    output logic [LVL_W-1:0]  rx_level,
    output logic              tx_ovf,
    output logic              tx_unf,
    output logic              rx_ovf,
    output logic              rx_unf,
    output logic              tx_rdy_n,
    output logic              rx_rdy_n,
    output logic              mf_n
);

    localparam int NQ = 2;

    rdy_cfg_t          cfg;
    logic              en_q;
    logic              flush;
    logic              q_push  [NQ];
    logic              q_pop   [NQ];
    logic [DATA_W-1:0] q_wdata [NQ];
    logic [DATA_W-1:0] q_rdata [NQ];
    logic [LVL_W-1:0]  q_level [NQ];
    logic              q_ovf   [NQ];
    logic              q_unf   [NQ];

    always_comb begin
        cfg.fifo_en    = cfg_fifo_en;
        cfg.block_mode = cfg_block_mode;
        cfg.rx_trig    = cfg_rx_trig;
        cfg.mf_sel     = cfg_mf_sel;
        flush          = en_q && !cfg_fifo_en;
        q_push[0]  = tx_push;  q_pop[0] = tx_pop;  q_wdata[0] = tx_wdata;
        q_push[1]  = rx_push;  q_pop[1] = rx_pop;  q_wdata[1] = rx_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= cfg_fifo_en;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        xfer_byte_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_q (
            .clk    (clk),
            .rst    (rst),
            .flush  (flush),
            .single (!cfg_fifo_en),
            .push   (q_push[g]),
            .wdata  (q_wdata[g]),
            .pop    (q_pop[g]),
            .rdata  (q_rdata[g]),
            .level  (q_level[g]),
            .ovf    (q_ovf[g]),
            .unf    (q_unf[g])
        );
    end

    assign tx_rdata = q_rdata[0];
    assign rx_rdata = q_rdata[1];
    assign tx_level = q_level[0];
    assign rx_level = q_level[1];
    assign tx_ovf   = q_ovf[0];
    assign tx_unf   = q_unf[0];
    assign rx_ovf   = q_ovf[1];
    assign rx_unf   = q_unf[1];

    xfer_ready_logic #(.DEPTH(DEPTH)) u_rdy (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .rx_timeout (rx_timeout),
        .tx_level   (q_level[0]),
        .rx_level   (q_level[1]),
        .tx_rdy_n   (tx_rdy_n),
        .rx_rdy_n   (rx_rdy_n),
        .mf_n       (mf_n)
    );

endmodule

// File: rtl/xfer_ready_unit_chk.sv
module xfer_ready_unit_chk #(
    parameter int DEPTH  = 128,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_fifo_en,
    input logic             cfg_block_mode,
    input logic [1:0]       cfg_mf_sel,
    input logic             tx_push,
    input logic             rx_pop,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             tx_ovf,
    input logic             rx_unf,
    input logic             tx_rdy_n,
    input logic             rx_rdy_n,
    input logic             mf_n
);

    logic blk;
    assign blk = cfg_fifo_en && cfg_block_mode;

    p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

    p_single_cap_r2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_fifo_en && !$past(cfg_fifo_en)) |-> (tx_level <= LVL_W'(1)) && (rx_level <= LVL_W'(1)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        tx_ovf |-> $past(tx_push) && (tx_level <= $past(tx_level)));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        rx_unf |-> $past(rx_pop) && ($past(rx_level) == '0));

    p_char_rx_r5: assert property (@(posedge clk) disable iff (rst)
        !blk |-> (rx_rdy_n == (rx_level == '0)));

    p_char_tx_r6: assert property (@(posedge clk) disable iff (rst)
        !blk |-> (tx_rdy_n == (tx_level != '0)));

    p_block_release_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_rdy_n) && blk && $past(blk)) |-> ($past(rx_level) == '0));

    p_block_tx_r10: assert property (@(posedge clk) disable iff (rst)
        blk |-> (tx_rdy_n == (tx_level == LVL_W'(DEPTH))));

    p_mf_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_mf_sel != 2'b10) |-> mf_n);

    p_flush_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_fifo_en) |=> (tx_level == '0) && (rx_level == '0));

endmodule

bind xfer_ready_unit xfer_ready_unit_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/xfer_ready_unit_bench.sv
module xfer_ready_unit_bench;

    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_fifo_en = 1'b0, cfg_block_mode = 1'b0;
    logic [7:0] cfg_rx_trig = 8'd1;
    logic [1:0] cfg_mf_sel = 2'b00;
    logic       rx_timeout = 1'b0;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0;
    logic [7:0] tx_rdata, rx_rdata, tx_level, rx_level;
    logic       tx_ovf, tx_unf, rx_ovf, rx_unf, tx_rdy_n, rx_rdy_n, mf_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xfer_ready_unit u_xfer_ready_unit (.*);

    // reference model state
    int m_txq[$], m_rxq[$];
    bit m_prev_en, m_latch, m_tovf, m_tunf, m_rovf, m_runf;

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_txq.delete(); m_rxq.delete();
        m_prev_en = 0; m_latch = 0;
        m_tovf = 0; m_tunf = 0; m_rovf = 0; m_runf = 0;
    endtask

    task automatic q_step(ref int q[$], input bit push, input int d, input bit pop,
                          input int cap, input bit fl, output bit ovf, output bit unf);
        int lvl = q.size();
        ovf = 0; unf = 0;
        if (fl) begin q.delete(); return; end
        ovf = push && (lvl >= cap);
        unf = pop && (lvl == 0);
        if (pop && lvl > 0) void'(q.pop_front());
        if (push && lvl < cap) q.push_back(d);
    endtask

    task automatic model_step();
        bit fl = m_prev_en && !cfg_fifo_en;
        int cap = cfg_fifo_en ? DEPTH : 1;
        int trig = (cfg_rx_trig == 0) ? 1 : int'(cfg_rx_trig);
        int rl = m_rxq.size();
        if (!(cfg_fifo_en && cfg_block_mode) || rl == 0) m_latch = 0;
        else if (rl >= trig || rx_timeout) m_latch = 1;
        q_step(m_txq, tx_push, int'(tx_wdata), tx_pop, cap, fl, m_tovf, m_tunf);
        q_step(m_rxq, rx_push, int'(rx_wdata), rx_pop, cap, fl, m_rovf, m_runf);
        m_prev_en = cfg_fifo_en;
    endtask

    task automatic compare();
        bit blk = cfg_fifo_en && cfg_block_mode;
        int e_tx = blk ? int'(m_txq.size() == DEPTH) : int'(m_txq.size() != 0);
        int e_rx = blk ? int'(!m_latch) : int'(m_rxq.size() == 0);
        check("R1", "tx_level", int'(tx_level), m_txq.size());
        check("R1", "rx_level", int'(rx_level), m_rxq.size());
        check("R3", "tx_ovf", int'(tx_ovf), int'(m_tovf));
        check("R3", "rx_ovf", int'(rx_ovf), int'(m_rovf));
        check("R4", "tx_unf", int'(tx_unf), int'(m_tunf));
        check("R4", "rx_unf", int'(rx_unf), int'(m_runf));
        check(blk ? "R10" : "R6", "tx_rdy_n", int'(tx_rdy_n), e_tx);
        check(blk ? "R7" : "R5", "rx_rdy_n", int'(rx_rdy_n), e_rx);
        check("R11", "mf_n", int'(mf_n), (cfg_mf_sel == 2'b10) ? e_rx : 1);
        if (m_txq.size() > 0) check("R13", "tx_rdata", int'(tx_rdata), m_txq[0]);
        if (m_rxq.size() > 0) check("R13", "rx_rdata", int'(rx_rdata), m_rxq[0]);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic op(bit tp, int td, bit tq, bit rp, int rd, bit rq, bit tmo);
        tx_push = tp; tx_wdata = 8'(td); tx_pop = tq;
        rx_push = rp; rx_wdata = 8'(rd); rx_pop = rq; rx_timeout = tmo;
        cyc();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; rx_timeout = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        compare();                                  // reset state
        check("R5", "reset rx_rdy_n", int'(rx_rdy_n), 1);
        check("R6", "reset tx_rdy_n", int'(tx_rdy_n), 0);

        // R2: holding-register behaviour with queues disabled
        op(1, 8'h11, 0, 1, 8'h22, 0, 0);
        check("R2", "hold tx_level", int'(tx_level), 1);
        op(1, 8'h33, 0, 1, 8'h44, 0, 0);             // R3 refused
        check("R2", "hold rx_rdata kept", int'(rx_rdata), 8'h22);
        op(0, 0, 1, 0, 0, 1, 0);
        op(0, 0, 1, 0, 0, 1, 0);                     // R4 underflow

        // R5/R6/R13: per-character mode
        cfg_fifo_en = 1; cyc();
        for (int i = 0; i < 5; i++) op(1, 8'h50 + i, 0, 1, 8'hA0 + i, 0, 0);
        for (int i = 0; i < 5; i++) op(0, 0, 1, 0, 0, 1, 0);

        // R1/R3/R10: fill transmit queue in block mode
        cfg_block_mode = 1; cfg_rx_trig = 8'd4; cfg_mf_sel = 2'b10; cyc();
        for (int i = 0; i < DEPTH + 2; i++) op(1, i, 0, 0, 0, 0, 0);
        check("R10", "full tx_rdy_n", int'(tx_rdy_n), 1);
        op(0, 0, 1, 0, 0, 0, 0);
        check("R10", "one free tx_rdy_n", int'(tx_rdy_n), 0);

        // R7: trigger and hysteresis
        for (int i = 0; i < 4; i++) op(0, 0, 0, 1, 8'hC0 + i, 0, 0);
        cyc();
        check("R7", "trigger hit rx_rdy_n", int'(rx_rdy_n), 0);
        for (int i = 0; i < 3; i++) op(0, 0, 0, 0, 0, 1, 0);
        check("R7", "held below trigger", int'(rx_rdy_n), 0);
        op(0, 0, 0, 0, 0, 1, 0); cyc();
        check("R7", "release on empty", int'(rx_rdy_n), 1);

        // R8: timeout
        op(0, 0, 0, 1, 8'h77, 0, 0);
        op(0, 0, 0, 0, 0, 0, 1); cyc();
        check("R8", "timeout rx_rdy_n", int'(rx_rdy_n), 0);
        op(0, 0, 0, 0, 0, 1, 0); cyc();

        // R9: zero trigger
        cfg_rx_trig = 8'd0; op(0, 0, 0, 1, 8'h5A, 0, 0); cyc();
        check("R9", "zero trigger rx_rdy_n", int'(rx_rdy_n), 0);

        // R11: select values
        cfg_mf_sel = 2'b01; cyc();
        check("R11", "mf_n off", int'(mf_n), 1);
        cfg_mf_sel = 2'b10; cyc();

        // R12: flush on disable
        op(1, 1, 0, 1, 2, 0, 0);
        cfg_fifo_en = 0; op(1, 3, 0, 1, 4, 0, 0);
        check("R12", "flush tx_level", int'(tx_level), 0);
        check("R12", "flush rx_level", int'(rx_level), 0);

        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 199) == 0) cfg_fifo_en = ~cfg_fifo_en;
            if ($urandom_range(0, 99) == 0) cfg_block_mode = ~cfg_block_mode;
            if ($urandom_range(0, 149) == 0) cfg_rx_trig = 8'($urandom_range(0, 140));
            if ($urandom_range(0, 99) == 0) cfg_mf_sel = 2'($urandom);
            op($urandom_range(0, 2) != 0, $urandom, $urandom_range(0, 2) == 0,
               $urandom_range(0, 2) != 0, $urandom, $urandom_range(0, 3) == 0,
               $urandom_range(0, 30) == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule